// File: doc/BRIEF.md
# STS-3 Byte-Interleave Multiplexer and Demultiplexer

This block has two independent directions. The transmit half takes up to three STS-1 byte streams, presented in parallel on a telecom bus, and interleaves them into one STS-3/STM-1 byte stream. The receive half takes one high-speed byte stream and splits it back out to the three tributaries. Both halves keep the byte order they see on the bus and do no regrouping of their own. Each half tracks its column, row and tributary slot from a frame sync that marks the first byte of row 1.

A byte strobe paces each direction. In the two three-tributary modes the strobe runs at the 19.44 MHz byte rate. In single STS-1 mode it runs at 6.48 MHz, one byte in three. Three modes are selected by `mode_i`. STS-3 and AU-4 both interleave three tributaries in the same order. STS-1 mode passes tributary 1 alone, with a row one third as wide.

Top module: `sts3_ilv_top`

## Requirements
- R1: While `rst_n` is low, every output is zero: bytes, valid strobes, columns and rows.
- R2: In STS-3 mode (`mode_i`=0), the byte in high-speed column c is tributary c mod 3. Tributary k sits at bits [8k+7:8k] of `tx_trib_i`. The byte appears on `tx_byte_o` with `tx_vld_o` high one clock after the edge at which `tx_ce_i` is high.
- R3: AU-4 mode (`mode_i`=1) gives the same interleave order and timing as STS-3 mode. Mode value 3 behaves as STS-3.
- R4: In STS-1 mode (`mode_i`=2), every byte is taken from tributary 0, and a row spans COLS_PER_TRIB columns.
- R5: The transmit time slot of a tributary whose `trib_en_i` bit is 0 carries 8'hFF.
- R6: A byte strobed with its sync input high is reported at column 0, row 0, and counting continues from there.
- R7: The column counts up to the row width minus 1 and then returns to 0 while the row advances. The row returns to 0 after ROWS-1.
- R8: A clock with the strobe low advances nothing. The valid output is low and the byte, column and row outputs hold their values.
- R9: Each received byte is driven on `rx_byte_o` one clock after its strobe. `rx_vld_o` is one-hot, with bit c mod 3 set for high-speed column c.
- R10: A received byte whose tributary is disabled raises no bit of `rx_vld_o`.
- R11: In STS-1 mode, every received byte raises bit 0 of `rx_vld_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 0 STS-3, 1 AU-4, 2 STS-1, 3 as STS-3 |
| trib_en_i | input | NUM_TRIB | Per-tributary enable |
| tx_ce_i | input | 1 | Transmit byte strobe |
| tx_sync_i | input | 1 | Transmit frame sync, first byte of row 1 |
| tx_trib_i | input | 8*NUM_TRIB | Tributary bytes from the bus |
| tx_byte_o | output | 8 | Interleaved high-speed byte |
| tx_vld_o | output | 1 | High-speed byte valid |
| tx_col_o | output | COL_W | Column of tx_byte_o |
| tx_row_o | output | ROW_W | Row of tx_byte_o |
| rx_ce_i | input | 1 | Receive byte strobe |
| rx_sync_i | input | 1 | Receive frame sync |
| rx_byte_i | input | 8 | High-speed byte in |
| rx_byte_o | output | 8 | De-interleaved byte |
| rx_vld_o | output | NUM_TRIB | One-hot tributary strobe |
| rx_col_o | output | COL_W | Column of rx_byte_o |
| rx_row_o | output | ROW_W | Row of rx_byte_o |

## Verification
The bench builds the block with three tributaries, 3 rows and 4 columns per tributary. A three-tributary frame is then 36 bytes and a single-tributary frame is 12. Column wraps, row wraps and frame wraps therefore occur many times within a few hundred clocks. That also leaves time to run every mode, gapped strobes, a disabled tributary and a sync that arrives mid-frame.

// File: rtl/sts3_ilv_pkg.sv
package sts3_ilv_pkg;
  typedef enum logic [1:0] {
    MODE_STS3 = 2'd0,
    MODE_AU4  = 2'd1,
    MODE_STS1 = 2'd2,
    MODE_RSVD = 2'd3
  } ilv_mode_e;

  localparam logic [7:0] IDLE_FILL = 8'hFF;
endpackage

// File: rtl/sts3_ilv_pos.sv
module sts3_ilv_pos #(
  parameter int NUM_TRIB = 3,
  parameter int ROWS = 9,
  parameter int COLS_PER_TRIB = 90,
  parameter int COL_W = 9,
  parameter int ROW_W = 4,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_i,
  input  logic              sync_i,
  input  logic              single_i,
  output logic [COL_W-1:0]  cur_col_o,
  output logic [ROW_W-1:0]  cur_row_o,
  output logic [SLOT_W-1:0] cur_slot_o
);
  localparam logic [COL_W-1:0]  LAST_WIDE   = COL_W'(NUM_TRIB*COLS_PER_TRIB - 1);
  localparam logic [COL_W-1:0]  LAST_NARROW = COL_W'(COLS_PER_TRIB - 1);
  localparam logic [ROW_W-1:0]  LAST_ROW    = ROW_W'(ROWS - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT   = SLOT_W'(NUM_TRIB - 1);

  logic [COL_W-1:0]  pos_col_q, pos_col_d;
  logic [ROW_W-1:0]  pos_row_q, pos_row_d;
  logic [SLOT_W-1:0] pos_slot_q, pos_slot_d;
  logic [COL_W-1:0]  last_col;

  always_comb begin
    cur_col_o  = sync_i ? '0 : pos_col_q;
    cur_row_o  = sync_i ? '0 : pos_row_q;
    cur_slot_o = (sync_i || single_i) ? '0 : pos_slot_q;
    last_col   = single_i ? LAST_NARROW : LAST_WIDE;
    if (cur_col_o >= last_col) begin
      pos_col_d  = '0;
      pos_slot_d = '0;
      pos_row_d  = (cur_row_o >= LAST_ROW) ? '0 : cur_row_o + 1'b1;
    end else begin
      pos_col_d  = cur_col_o + 1'b1;
      pos_row_d  = cur_row_o;
      pos_slot_d = (single_i || cur_slot_o >= LAST_SLOT) ? '0 : cur_slot_o + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_col_q  <= '0;
      pos_row_q  <= '0;
      pos_slot_q <= '0;
    end else if (ce_i) begin
      pos_col_q  <= pos_col_d;
      pos_row_q  <= pos_row_d;
      pos_slot_q <= pos_slot_d;
    end
  end

  AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |=> $stable({pos_col_q, pos_row_q, pos_slot_q})) else $error("hold"); // R8
endmodule

// File: rtl/sts3_ilv_mux.sv
module sts3_ilv_mux
  import sts3_ilv_pkg::*;
#(
  parameter int NUM_TRIB = 3,
  parameter int COL_W = 9,
  parameter int ROW_W = 4,
  parameter int SLOT_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce_i,
  input  logic [NUM_TRIB-1:0]   trib_en_i,
  input  logic [8*NUM_TRIB-1:0] trib_i,
  input  logic [SLOT_W-1:0]     slot_i,
  input  logic [COL_W-1:0]      col_i,
  input  logic [ROW_W-1:0]      row_i,
  output logic [7:0]            byte_o,
  output logic                  vld_o,
  output logic [COL_W-1:0]      col_o,
  output logic [ROW_W-1:0]      row_o
);
  logic [7:0] byte_d;

  always_comb begin
    byte_d = IDLE_FILL;
    for (int k = 0; k < NUM_TRIB; k++) begin
      if (slot_i == SLOT_W'(k) && trib_en_i[k]) byte_d = trib_i[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_o <= '0;
      col_o  <= '0;
      row_o  <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= ce_i;
      if (ce_i) begin
        byte_o <= byte_d;
        col_o  <= col_i;
        row_o  <= row_i;
      end
    end
  end

  AST_FILL_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ce_i && !trib_en_i[slot_i] |=> byte_o == IDLE_FILL) else $error("fill"); // R5
endmodule

// File: rtl/sts3_ilv_demux.sv
module sts3_ilv_demux #(
  parameter int NUM_TRIB = 3,
  parameter int COL_W = 9,
  parameter int ROW_W = 4,
  parameter int SLOT_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_i,
  input  logic [NUM_TRIB-1:0] trib_en_i,
  input  logic [7:0]          byte_i,
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic [COL_W-1:0]    col_i,
  input  logic [ROW_W-1:0]    row_i,
  output logic [7:0]          byte_o,
  output logic [NUM_TRIB-1:0] vld_o,
  output logic [COL_W-1:0]    col_o,
  output logic [ROW_W-1:0]    row_o
);
  logic [NUM_TRIB-1:0] vld_d;

  generate
    for (genvar k = 0; k < NUM_TRIB; k++) begin : g_strobe
      assign vld_d[k] = ce_i && trib_en_i[k] && (slot_i == SLOT_W'(k));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_o <= '0;
      col_o  <= '0;
      row_o  <= '0;
      vld_o  <= '0;
    end else begin
      vld_o <= vld_d;
      if (ce_i) begin
        byte_o <= byte_i;
        col_o  <= col_i;
        row_o  <= row_i;
      end
    end
  end

  AST_DIS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ce_i && !trib_en_i[slot_i] |=> vld_o == '0) else $error("dis"); // R10
endmodule

// File: rtl/sts3_ilv_top.sv
module sts3_ilv_top
  import sts3_ilv_pkg::*;
#(
  parameter int NUM_TRIB = 3,
  parameter int ROWS = 9,
  parameter int COLS_PER_TRIB = 90,
  parameter int COL_W = $clog2(NUM_TRIB*COLS_PER_TRIB),
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            mode_i,
  input  logic [NUM_TRIB-1:0]   trib_en_i,
  input  logic                  tx_ce_i,
  input  logic                  tx_sync_i,
  input  logic [8*NUM_TRIB-1:0] tx_trib_i,
  output logic [7:0]            tx_byte_o,
  output logic                  tx_vld_o,
  output logic [COL_W-1:0]      tx_col_o,
  output logic [ROW_W-1:0]      tx_row_o,
  input  logic                  rx_ce_i,
  input  logic                  rx_sync_i,
  input  logic [7:0]            rx_byte_i,
  output logic [7:0]            rx_byte_o,
  output logic [NUM_TRIB-1:0]   rx_vld_o,
  output logic [COL_W-1:0]      rx_col_o,
  output logic [ROW_W-1:0]      rx_row_o
);
  localparam int SLOT_W = (NUM_TRIB > 1) ? $clog2(NUM_TRIB) : 1;

  logic              single;
  logic [COL_W-1:0]  tx_col, rx_col;
  logic [ROW_W-1:0]  tx_row, rx_row;
  logic [SLOT_W-1:0] tx_slot, rx_slot;

  assign single = (mode_i == MODE_STS1);

  sts3_ilv_pos #(.NUM_TRIB(NUM_TRIB), .ROWS(ROWS), .COLS_PER_TRIB(COLS_PER_TRIB),
                 .COL_W(COL_W), .ROW_W(ROW_W), .SLOT_W(SLOT_W)) u_tx_pos (
    .clk(clk), .rst_n(rst_n), .ce_i(tx_ce_i), .sync_i(tx_sync_i), .single_i(single),
    .cur_col_o(tx_col), .cur_row_o(tx_row), .cur_slot_o(tx_slot));

  sts3_ilv_pos #(.NUM_TRIB(NUM_TRIB), .ROWS(ROWS), .COLS_PER_TRIB(COLS_PER_TRIB),
                 .COL_W(COL_W), .ROW_W(ROW_W), .SLOT_W(SLOT_W)) u_rx_pos (
    .clk(clk), .rst_n(rst_n), .ce_i(rx_ce_i), .sync_i(rx_sync_i), .single_i(single),
    .cur_col_o(rx_col), .cur_row_o(rx_row), .cur_slot_o(rx_slot));

  sts3_ilv_mux #(.NUM_TRIB(NUM_TRIB), .COL_W(COL_W), .ROW_W(ROW_W), .SLOT_W(SLOT_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .ce_i(tx_ce_i), .trib_en_i(trib_en_i), .trib_i(tx_trib_i),
    .slot_i(tx_slot), .col_i(tx_col), .row_i(tx_row),
    .byte_o(tx_byte_o), .vld_o(tx_vld_o), .col_o(tx_col_o), .row_o(tx_row_o));

  sts3_ilv_demux #(.NUM_TRIB(NUM_TRIB), .COL_W(COL_W), .ROW_W(ROW_W), .SLOT_W(SLOT_W)) u_demux (
    .clk(clk), .rst_n(rst_n), .ce_i(rx_ce_i), .trib_en_i(trib_en_i), .byte_i(rx_byte_i),
    .slot_i(rx_slot), .col_i(rx_col), .row_i(rx_row),
    .byte_o(rx_byte_o), .vld_o(rx_vld_o), .col_o(rx_col_o), .row_o(rx_row_o));

  AST_TX_SYNC_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ce_i && tx_sync_i |=> tx_col_o == '0 && tx_row_o == '0) else $error("txsync"); // R6
  AST_RX_SYNC_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ce_i && rx_sync_i |=> rx_col_o == '0 && rx_row_o == '0) else $error("rxsync"); // R6
  AST_RX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_vld_o)) else $error("onehot"); // R9
  AST_TX_IDLE_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ce_i |=> !tx_vld_o && $stable(tx_byte_o)) else $error("txidle"); // R8
endmodule

// File: tb/sts3_ilv_top_tb_top.sv
module sts3_ilv_top_tb_top;
  localparam int NT = 3;
  localparam int ROWS = 3;
  localparam int CPT = 4;
  localparam int CW = $clog2(NT*CPT);
  localparam int RW = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [NT-1:0] en = '1;
  logic tx_ce = 1'b0, tx_sync = 1'b0, rx_ce = 1'b0, rx_sync = 1'b0;
  logic [8*NT-1:0] tx_trib = '0;
  logic [7:0] rx_in = '0;
  logic [7:0] tx_byte, rx_byte;
  logic tx_vld;
  logic [NT-1:0] rx_vld;
  logic [CW-1:0] tx_col, rx_col;
  logic [RW-1:0] tx_row, rx_row;

  int vectors = 0, errors = 0;
  string tag = "R1";

  int t_col = 0, t_row = 0, t_slot = 0, r_col = 0, r_row = 0, r_slot = 0;
  int e_tbyte = 0, e_tvld = 0, e_tcol = 0, e_trow = 0;
  int e_rbyte = 0, e_rvld = 0, e_rcol = 0, e_rrow = 0;

  always #2.5 clk = ~clk;

  sts3_ilv_top #(.NUM_TRIB(NT), .ROWS(ROWS), .COLS_PER_TRIB(CPT)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .trib_en_i(en),
    .tx_ce_i(tx_ce), .tx_sync_i(tx_sync), .tx_trib_i(tx_trib),
    .tx_byte_o(tx_byte), .tx_vld_o(tx_vld), .tx_col_o(tx_col), .tx_row_o(tx_row),
    .rx_ce_i(rx_ce), .rx_sync_i(rx_sync), .rx_byte_i(rx_in),
    .rx_byte_o(rx_byte), .rx_vld_o(rx_vld), .rx_col_o(rx_col), .rx_row_o(rx_row));

  task automatic chk(string what, int act, int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    vectors++;
    chk("tx_byte", int'(tx_byte), e_tbyte);
    chk("tx_vld", int'(tx_vld), e_tvld);
    chk("tx_col", int'(tx_col), e_tcol);
    chk("tx_row", int'(tx_row), e_trow);
    chk("rx_byte", int'(rx_byte), e_rbyte);
    chk("rx_vld", int'(rx_vld), e_rvld);
    chk("rx_col", int'(rx_col), e_rcol);
    chk("rx_row", int'(rx_row), e_rrow);
  endtask

  // Reference model of the frame walk, updated on each rising edge.
  always @(posedge clk) begin
    if (rst_n) begin
      int width;
      bit one;
      one = (mode == 2'd2);
      width = one ? CPT : NT*CPT;
      e_tvld = 0;
      e_rvld = 0;
      if (tx_ce) begin
        if (tx_sync) begin t_col = 0; t_row = 0; t_slot = 0; end
        if (one) t_slot = 0;
        e_tbyte = en[t_slot] ? int'(tx_trib[8*t_slot +: 8]) : 8'hFF;
        e_tvld = 1; e_tcol = t_col; e_trow = t_row;
        t_col++; t_slot = one ? 0 : (t_slot + 1) % NT;
        if (t_col >= width) begin t_col = 0; t_slot = 0; t_row = (t_row + 1) % ROWS; end
      end
      if (rx_ce) begin
        if (rx_sync) begin r_col = 0; r_row = 0; r_slot = 0; end
        if (one) r_slot = 0;
        e_rbyte = int'(rx_in);
        e_rvld = en[r_slot] ? (1 << r_slot) : 0;
        e_rcol = r_col; e_rrow = r_row;
        r_col++; r_slot = one ? 0 : (r_slot + 1) % NT;
        if (r_col >= width) begin r_col = 0; r_slot = 0; r_row = (r_row + 1) % ROWS; end
      end
    end
  end

  // One clock: drive at the falling edge, compare at the next falling edge.
  task automatic step(bit ce, bit sync, int seed);
    tx_ce = ce; rx_ce = ce; tx_sync = sync; rx_sync = sync;
    for (int k = 0; k < NT; k++) tx_trib[8*k +: 8] = 8'((seed * 7 + k * 61 + 3) & 8'hFE);
    rx_in = 8'(seed * 13 + 5);
    @(negedge clk);
    compare();
  endtask

  task automatic run(int n, int gap, int sync_at);
    for (int i = 0; i < n; i++) begin
      bit ce;
      ce = (gap == 0) || (i % (gap + 1) == 0);
      step(ce, ce && (i == sync_at), i);
    end
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    tag = "R1";
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1'b1;
    @(negedge clk); compare();
    tag = "R2/R7/R9"; mode = 2'd0; en = '1;
    run(90, 0, 0);
    tag = "R8"; run(60, 2, 1000);
    tag = "R3"; mode = 2'd1; run(40, 0, 0);
    mode = 2'd3; run(40, 0, 0);
    tag = "R5/R10"; mode = 2'd0; en = 3'b101; run(40, 0, 0);
    en = 3'b010; run(40, 0, 5);
    tag = "R4/R11"; mode = 2'd2; en = '1; run(90, 2, 0);
    en = 3'b110; run(20, 2, 0);
    tag = "R6"; mode = 2'd0; en = '1; run(30, 0, 7);
    run(30, 0, 17);
    tag = "R8"; run(10, 9, 1000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule